// File: doc/BRIEF.md
# Accumulating Ping-Pong Result Cache with Max Pooling

This block stores the column results of a multiply-accumulate array in a per-channel memory. Each accepted beat carries one 16-bit signed value per channel and a word address. The beat can overwrite that address. It can also add itself to the partial sum already held there, which sums a multi-channel convolution one input channel at a time. In a third mode it adds in the same way and then reduces aligned groups of consecutive sums to their maximum, optionally clamping the result at zero, before writing it back. Sums saturate at the 16-bit signed limits.

Two banks of the same shape form a ping-pong pair. One bank collects results and the other serves reads for the next layer. The roles change only on an explicit swap pulse between layers. A read returns the addressed word of every channel at once (column readout), together with the value of one selected channel (row readout).

Both request streams use valid/ready. A beat transfers on a cycle where valid and ready are both high. Ready drops only in the cycle in which `swap_i` is high, so no beat or read can straddle a role change. Valid and payload must be held while ready is low. The read response has a fixed latency of one cycle and no back-pressure.

Top module: `rc_accum_cache`

## Requirements
- R1: A beat accepted with mode 0 (overwrite) stores each channel value at `in_addr`. Channel i occupies bits [16i+15:16i] of `in_data` and of `rsp_col_data`.
- R2: With mode 1 (accumulate), each channel stores the stored value plus the new value at `in_addr`.
- R3: Accumulation saturates at 32767 and -32768 instead of wrapping.
- R4: Beats to the same address on consecutive cycles accumulate correctly, each one seeing the sum left by the previous one.
- R5: With mode 2 (pool), sums are formed as in R2. Each aligned group of 2^`pool_log2` consecutive addresses is reduced to its maximum, and that maximum is written at address `in_addr >> pool_log2` when the last beat of the group arrives. Beats of a group arrive in ascending address order.
- R6: In pool mode with `act_en`=1 the written value is max(group maximum, 0). With `act_en`=0 a negative maximum is written unchanged.
- R7: After reset bank 0 collects and bank 1 serves reads. Each cycle with `swap_i`=1 exchanges the roles and holds `in_ready` and `rd_ready` low.
- R8: A beat whose `in_bank` is not the collecting bank is ignored, and the serving bank keeps its contents.
- R9: A read whose `rd_bank` is not the serving bank is ignored: `rsp_valid` stays low in the following cycle.
- R10: A read accepted on the serving bank raises `rsp_valid` one cycle later. `rsp_col_data` then holds all channels at `rd_addr`, and `rsp_row_data` holds channel `rd_chan`.
- R11: After reset `rsp_valid` is low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Result beat valid |
| in_ready | output | 1 | Result beat ready |
| in_bank | input | 1 | Target bank of the beat |
| in_addr | input | AW | Word address of the beat |
| in_data | input | NCH*16 | One signed value per channel |
| in_mode | input | 2 | 0 overwrite, 1 accumulate, 2 accumulate then pool |
| pool_log2 | input | PLW | Log2 of the pooling group length |
| act_en | input | 1 | Clamp pooled result at zero |
| swap_i | input | 1 | Exchange bank roles |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_bank | input | 1 | Bank to read |
| rd_addr | input | AW | Word address to read |
| rd_chan | input | CW | Channel for row readout |
| rsp_valid | output | 1 | Read response valid |
| rsp_col_data | output | NCH*16 | All channels at the read address |
| rsp_row_data | output | 16 | Selected channel at the read address |

## Verification
The bench builds the block with four channels, sixteen words per bank and a two-bit pool exponent. At that size each lane value can be written out by hand. Pooled results land at addresses well below the inputs that produce them. Saturation is reached from both sides in a single pair of beats. Back-to-back beats to one address exercise the write forwarding. The bench also shows ignored writes and ignored reads at the ports through the normal read path.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    RC_OVW  = 2'd0,
    RC_ACC  = 2'd1,
    RC_POOL = 2'd2
  } rc_mode_e;

  function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [DW:0] s;
    s = $signed({a[DW-1], a}) + $signed({b[DW-1], b});
    if (s > $signed({2'b00, {(DW-1){1'b1}}}))       sat_add = {1'b0, {(DW-1){1'b1}}};
    else if (s < $signed({2'b11, {(DW-1){1'b0}}}))  sat_add = {1'b1, {(DW-1){1'b0}}};
    else                                            sat_add = s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] smax(input logic [DW-1:0] a, input logic [DW-1:0] b);
    smax = ($signed(a) > $signed(b)) ? a : b;
  endfunction
endpackage

// File: rtl/rc_ram.sv
module rc_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rc_lane.sv
module rc_lane
  import rc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  rc_mode_e      mode,
  input  logic          act_en,
  input  logic          first,
  input  logic          we,
  input  logic [DW-1:0] new_v,
  input  logic [DW-1:0] ram_v,
  input  logic          fwd_hit,
  output logic [DW-1:0] wval
);
  logic [DW-1:0] last_w, run_max, old_v, sum, grp_max;

  assign old_v   = fwd_hit ? last_w : ram_v;
  assign sum     = sat_add(old_v, new_v);
  assign grp_max = first ? sum : smax(run_max, sum);

  always_comb begin
    unique case (mode)
      RC_OVW:  wval = new_v;
      RC_ACC:  wval = sum;
      default: wval = (act_en && grp_max[DW-1]) ? '0 : grp_max;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_w  <= '0;
      run_max <= '0;
    end else begin
      if (we) last_w <= wval;
      if (s_valid && mode == RC_POOL) run_max <= grp_max;
    end
  end

  // R3: two non-negative operands never produce a negative sum
  a_r3_no_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && mode != RC_OVW && !old_v[DW-1] && !new_v[DW-1]) |-> !sum[DW-1]);
  // R3: two negative operands never produce a non-negative sum
  a_r3_no_neg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && mode != RC_OVW && old_v[DW-1] && new_v[DW-1]) |-> sum[DW-1]);
  // R6: clamped pool writes are never negative
  a_r6_relu_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (we && mode == RC_POOL && act_en) |-> !wval[DW-1]);
endmodule

// File: rtl/rc_accum_cache.sv
module rc_accum_cache
  import rc_pkg::*;
#(
  parameter int NCH   = 32,
  parameter int DEPTH = 32,
  parameter int PLW   = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bank,
  input  logic [AW-1:0]     in_addr,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [1:0]        in_mode,
  input  logic [PLW-1:0]    pool_log2,
  input  logic              act_en,
  input  logic              swap_i,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              rd_bank,
  input  logic [AW-1:0]     rd_addr,
  input  logic [CW-1:0]     rd_chan,
  output logic              rsp_valid,
  output logic [NCH*DW-1:0] rsp_col_data,
  output logic [DW-1:0]     rsp_row_data
);
  logic coll;
  logic acc_in, acc_rd;

  logic              s1_valid, s1_bank, s1_act;
  logic [AW-1:0]     s1_addr;
  rc_mode_e          s1_mode;
  logic [PLW-1:0]    s1_plog;
  logic [NCH*DW-1:0] s1_data;

  logic              wb_valid, wb_bank;
  logic [AW-1:0]     wb_addr;

  logic [AW-1:0]     mask, waddr;
  logic              first, last, s1_we, fwd_hit;
  logic [1:0]        bank_we;
  logic [AW-1:0]     bank_raddr [2];
  logic [DW-1:0]     bank_rd    [2][NCH];
  logic [DW-1:0]     wval       [NCH];

  logic              rsp_bank_q;
  logic [CW-1:0]     rsp_chan_q;

  assign in_ready = !swap_i;
  assign rd_ready = !swap_i;
  assign acc_in   = in_valid && in_ready && (in_bank == coll);
  assign acc_rd   = rd_valid && rd_ready && (rd_bank != coll);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll       <= 1'b0;
      s1_valid   <= 1'b0;
      s1_bank    <= 1'b0;
      s1_addr    <= '0;
      s1_mode    <= RC_OVW;
      s1_plog    <= '0;
      s1_act     <= 1'b0;
      s1_data    <= '0;
      wb_valid   <= 1'b0;
      wb_bank    <= 1'b0;
      wb_addr    <= '0;
      rsp_valid  <= 1'b0;
      rsp_bank_q <= 1'b0;
      rsp_chan_q <= '0;
    end else begin
      if (swap_i) coll <= !coll;
      s1_valid <= acc_in;
      if (acc_in) begin
        s1_bank <= in_bank;
        s1_addr <= in_addr;
        s1_mode <= rc_mode_e'(in_mode);
        s1_plog <= pool_log2;
        s1_act  <= act_en;
        s1_data <= in_data;
      end
      wb_valid <= s1_we;
      if (s1_we) begin
        wb_bank <= s1_bank;
        wb_addr <= waddr;
      end
      rsp_valid <= acc_rd;
      if (acc_rd) begin
        rsp_bank_q <= rd_bank;
        rsp_chan_q <= rd_chan;
      end
    end
  end

  assign mask    = ~({AW{1'b1}} << s1_plog);
  assign first   = (s1_addr & mask) == '0;
  assign last    = (s1_addr & mask) == mask;
  assign s1_we   = s1_valid && (s1_mode != RC_POOL || last);
  assign waddr   = (s1_mode == RC_POOL) ? (s1_addr >> s1_plog) : s1_addr;
  assign fwd_hit = wb_valid && (wb_bank == s1_bank) && (wb_addr == s1_addr);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_we[b]    = s1_we && (s1_bank == 1'(b));
    assign bank_raddr[b] = (coll == 1'(b)) ? in_addr : rd_addr;
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      rc_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (bank_we[b]),
        .waddr (waddr),
        .wdata (wval[c]),
        .raddr (bank_raddr[b]),
        .rdata (bank_rd[b][c])
      );
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    rc_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (s1_valid),
      .mode    (s1_mode),
      .act_en  (s1_act),
      .first   (first),
      .we      (s1_we),
      .new_v   (s1_data[c*DW +: DW]),
      .ram_v   (bank_rd[s1_bank][c]),
      .fwd_hit (fwd_hit),
      .wval    (wval[c])
    );
    assign rsp_col_data[c*DW +: DW] = bank_rd[rsp_bank_q][c];
  end

  assign rsp_row_data = bank_rd[rsp_bank_q][rsp_chan_q];

  // R9: a read aimed at the collecting bank yields no response
  a_r9_no_rsp_collect: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_bank == coll) |=> !rsp_valid);
  // R8: bank 0 is written only after a beat accepted while it collected
  a_r8_write_role0: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we[0] |-> ($past(coll) == 1'b0 && $past(in_valid)));
  // R8: bank 1 is written only after a beat accepted while it collected
  a_r8_write_role1: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we[1] |-> ($past(coll) == 1'b1 && $past(in_valid)));
  // R10: a response always follows a read request
  a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_valid));
endmodule

// File: tb/rc_accum_cache_tb.sv
module rc_accum_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DEPTH = 16;
  localparam int PLW = 2;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bank = 1'b0, act_en = 1'b0, swap_i = 1'b0;
  logic [AW-1:0] in_addr = '0, rd_addr = '0;
  logic [NCH*16-1:0] in_data = '0;
  logic [1:0] in_mode = '0;
  logic [PLW-1:0] pool_log2 = '0;
  logic rd_valid = 1'b0, rd_bank = 1'b0;
  logic [CW-1:0] rd_chan = '0;
  logic in_ready, rd_ready, rsp_valid;
  logic [NCH*16-1:0] rsp_col_data;
  logic [15:0] rsp_row_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_accum_cache #(.NCH(NCH), .DEPTH(DEPTH), .PLW(PLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bank(in_bank), .in_addr(in_addr), .in_data(in_data), .in_mode(in_mode),
    .pool_log2(pool_log2), .act_en(act_en), .swap_i(swap_i),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_chan(rd_chan), .rsp_valid(rsp_valid), .rsp_col_data(rsp_col_data),
    .rsp_row_data(rsp_row_data)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic push(input bit bank, input int addr, input int mode, input int plog,
                      input bit act, input int v0, input int v1, input int v2, input int v3);
    in_valid  = 1'b1;
    in_bank   = bank;
    in_addr   = AW'(addr);
    in_mode   = 2'(mode);
    pool_log2 = PLW'(plog);
    act_en    = act;
    in_data   = {16'(v3), 16'(v2), 16'(v1), 16'(v0)};
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic swap(input string req);
    swap_i = 1'b1;
    #1;
    chk({req, " in_ready low in swap"}, int'(in_ready), 0);
    chk({req, " rd_ready low in swap"}, int'(rd_ready), 0);
    @(negedge clk);
    swap_i = 1'b0;
  endtask

  task automatic rd_check(input string req, input bit bank, input int addr, input int chan,
                          input int e0, input int e1, input int e2, input int e3);
    int ex [4];
    ex = '{e0, e1, e2, e3};
    rd_valid = 1'b1; rd_bank = bank; rd_addr = AW'(addr); rd_chan = CW'(chan);
    @(negedge clk);
    rd_valid = 1'b0;
    chk({req, " rsp_valid"}, int'(rsp_valid), 1);
    for (int i = 0; i < NCH; i++)
      chk({req, " column lane"}, int'($signed(rsp_col_data[i*16 +: 16])), ex[i]);
    chk({req, " row lane"}, int'($signed(rsp_row_data)), ex[chan]);
  endtask

  task automatic t_reset;
    chk("R11 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R11 in_ready after reset", int'(in_ready), 1);
    chk("R11 rd_ready after reset", int'(rd_ready), 1);
  endtask

  task automatic t_overwrite;
    push(0, 3, 0, 0, 0, 10, -20, 30, -40);
    swap("R7");
    rd_check("R1 R10 overwrite readout", 0, 3, 2, 10, -20, 30, -40);
  endtask

  task automatic t_ignore;
    push(0, 3, 0, 0, 0, 99, 99, 99, 99);
    rd_check("R8 write to serving bank ignored", 0, 3, 0, 10, -20, 30, -40);
    rd_valid = 1'b1; rd_bank = 1'b1; rd_addr = AW'(3);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R9 read of collecting bank ignored", int'(rsp_valid), 0);
  endtask

  task automatic t_accum;
    swap("R7");
    push(0, 3, 1, 0, 0, 1, 2, 3, 4);
    push(0, 3, 1, 0, 0, 5, 5, 5, 5);
    swap("R7");
    rd_check("R2 R4 back-to-back accumulate", 0, 3, 1, 16, -13, 38, -31);
  endtask

  task automatic t_sat;
    swap("R7");
    push(0, 7, 0, 0, 0, 32000, -32000, 100, 0);
    push(0, 7, 1, 0, 0, 1000, -1000, -200, 0);
    swap("R7");
    rd_check("R3 saturation", 0, 7, 0, 32767, -32768, -100, 0);
  endtask

  task automatic t_pool;
    swap("R7");
    push(0, 8, 0, 0, 0, 1, -5, 0, 0);
    push(0, 9, 0, 0, 0, 2, -5, 0, 0);
    push(0, 10, 0, 0, 0, 3, -5, 0, 0);
    push(0, 11, 0, 0, 0, 4, -5, 0, 0);
    push(0, 12, 0, 0, 0, -3, -5, 5, 0);
    push(0, 13, 0, 0, 0, -7, -5, 9, 0);
    push(0, 8, 2, 1, 0, 10, 0, -1, 0);
    push(0, 9, 2, 1, 0, -10, 0, -2, 0);
    push(0, 10, 2, 1, 0, 0, 0, 0, 0);
    push(0, 11, 2, 1, 0, 0, 0, 0, 0);
    push(0, 12, 2, 1, 1, 0, 0, 0, 0);
    push(0, 13, 2, 1, 1, 0, 0, 0, 0);
    swap("R7");
    rd_check("R5 pool group 8-9 to addr 4", 0, 4, 0, 11, -5, -1, 0);
    rd_check("R5 R6 pool group 10-11 no clamp", 0, 5, 1, 4, -5, 0, 0);
    rd_check("R6 pool group 12-13 clamped", 0, 6, 2, 0, 0, 9, 0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_overwrite();
    t_ignore();
    t_accum();
    t_sat();
    t_pool();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule